// File: doc/BRIEF.md
# USB Control Endpoint Register File

This block holds the two CPU-visible registers that a small USB device needs for its control endpoint: the device address register and the endpoint-0 mode/status register. It sits between a simple CPU register bus (address, write data, write strobe, read strobe, combinational read data) and the serial interface engine (SIE). The SIE reads the address and its enable to decide which packets to answer. It writes the endpoint-0 status and mode fields through its own strobe, and it drives a level that marks the SETUP data-to-ACK window.

The mode/status register protects fresh status from the CPU. Every SIE update arms a write lock. While the lock is set, CPU writes to the register are dropped. Only a CPU read of the register releases the lock, so firmware has to look at new status before it can overwrite it. An accepted CPU write always wipes the upper status nibble and loads the low mode nibble. While the SETUP window level is high, the SETUP flag is held at 1 and cannot be cleared.

Top module: `usb_ep0_regs`

## Requirements
- R1: After hardware reset (rstN low), both registers read 0. The address enable, the device address and the mode output are all 0, and the lock is clear.
- R2: A CPU write to address 0x10 loads the device address register. Bit 7 appears on addrEn and bits 6:0 appear on devAddr from the next cycle. A read of 0x10 returns the stored byte.
- R3: A cycle with busRst high clears the device address register. It wins over a CPU write to 0x10 in the same cycle. The mode register is not touched.
- R4: An unlocked CPU write to address 0x12 sets bits 3:0 to the written bits 3:0 and clears bits 7:4, whatever value is written.
- R5: A cycle with sieWr high loads sieWrData into mode bits 6:0 and sets the lock. While the lock is set, CPU writes to 0x12 leave the register unchanged.
- R6: A CPU read of 0x12 returns the register value held before that clock edge. It releases the lock, so a later CPU write takes effect.
- R7: When sieWr and a CPU write to 0x12 fall in the same cycle, the SIE data is stored, the CPU data is dropped, and the lock is set.
- R8: When sieWr and a CPU read of 0x12 fall in the same cycle, the lock stays set.
- R9: While setupWin is high, mode bit 7 is 1 from the next cycle on. A CPU write in the window still applies its other effects but leaves bit 7 at 1. After the window, bit 7 keeps its value until an accepted CPU write clears it.
- R10: Reads of any other address return 0. Writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| busRst | input | 1 | USB bus reset seen by the SIE, synchronous, active high |
| cpuAddr | input | 8 | CPU register address |
| cpuWrData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe |
| cpuRdData | output | 8 | CPU read data, valid in the cycle of cpuAddr |
| sieWr | input | 1 | SIE update strobe for mode bits 6:0 |
| sieWrData | input | 7 | SIE data for mode bits 6:0 |
| setupWin | input | 1 | High from SETUP data phase start to ACK start |
| addrEn | output | 1 | Device address enable |
| devAddr | output | 7 | Device address |
| epMode | output | 8 | Endpoint-0 mode/status register contents |

## Verification
A stuck or wrongly released lock never shows up directly at the ports. It shows up on the first later CPU write to 0x12: epMode either changes when it should have held, or holds when it should have changed, one cycle after that write. A corrupted address or mode bit appears on devAddr, addrEn or epMode one cycle after the edge that caused it. Stale read data appears in the same cycle as the read. For these reasons the bench follows every register update with a read and a write, and it compares all outputs in every cycle.

// File: rtl/ep0_regs_pkg.sv
package ep0_regs_pkg;

  localparam int DATA_W     = 8;
  localparam int DEV_ADDR_W = 7;
  localparam int MODE_W     = 4;
  localparam int SIE_W      = DATA_W - 1;
  localparam int SETUP_BIT  = DATA_W - 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_MODE = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   addrWr;
    logic   addrClr;
    logic   modeCpuWr;
    logic   modeSieWr;
    logic   setupForce;
    rdSel_e rdSel;
  } ep0Strobes_t;

endpackage

// File: rtl/ep0_ctrl.sv
module ep0_ctrl
  import ep0_regs_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_OFS  = 8'h10,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic              sieWr,
  input  logic              setupWin,
  output ep0Strobes_t       st,
  output logic              lockQ
);

  logic hitDev;
  logic hitMode;
  logic lockSet;
  logic lockClr;

  assign hitDev  = (cpuAddr == DEV_OFS);
  assign hitMode = (cpuAddr == MODE_OFS);

  // The SIE always wins; a read only releases when no update lands with it.
  assign lockSet = sieWr;
  assign lockClr = cpuRd && hitMode && !sieWr;

  always_comb begin
    st            = '0;
    st.addrClr    = busRst;
    st.addrWr     = cpuWr && hitDev && !busRst;
    st.modeSieWr  = sieWr;
    st.modeCpuWr  = cpuWr && hitMode && !lockQ && !sieWr;
    st.setupForce = setupWin;
    if (hitDev)       st.rdSel = SEL_ADDR;
    else if (hitMode) st.rdSel = SEL_MODE;
    else              st.rdSel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lockQ <= 1'b0;
    else if (lockSet) lockQ <= 1'b1;
    else if (lockClr) lockQ <= 1'b0;
  end

  // R5: an SIE update always leaves the register locked
  p_sie_sets_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    sieWr |=> lockQ);

  // R8: a read that coincides with an SIE update does not unlock
  p_read_vs_sie_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sieWr && cpuRd && hitMode) |=> lockQ);

  // R6: a lone read of the mode register unlocks
  p_read_unlocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && hitMode && !sieWr) |=> !lockQ);

  // R7: a write in a locked or contended cycle is never granted
  p_no_grant_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ || sieWr) |-> !st.modeCpuWr);

endmodule

// File: rtl/ep0_datapath.sv
module ep0_datapath
  import ep0_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ep0Strobes_t           st,
  input  logic [DATA_W-1:0]     cpuWrData,
  input  logic [SIE_W-1:0]      sieWrData,
  output logic [DATA_W-1:0]     cpuRdData,
  output logic                  addrEn,
  output logic [DEV_ADDR_W-1:0] devAddr,
  output logic [DATA_W-1:0]     epMode
);

  logic [DATA_W-1:0] addrQ;
  logic [DATA_W-1:0] modeQ;
  logic [DATA_W-1:0] modeNxt;

  // Device address register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          addrQ <= '0;
    else if (st.addrClr) addrQ <= '0;
    else if (st.addrWr)  addrQ <= cpuWrData;
  end

  // Mode/status next-state: SIE update, else accepted CPU write; SETUP force on top
  always_comb begin
    modeNxt = modeQ;
    if (st.modeSieWr) begin
      modeNxt[SIE_W-1:0] = sieWrData;
    end else if (st.modeCpuWr) begin
      modeNxt[DATA_W-1:MODE_W] = '0;
      modeNxt[MODE_W-1:0]      = cpuWrData[MODE_W-1:0];
    end
    if (st.setupForce) modeNxt[SETUP_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= '0;
    else       modeQ <= modeNxt;
  end

  always_comb begin
    unique case (st.rdSel)
      SEL_ADDR: cpuRdData = addrQ;
      SEL_MODE: cpuRdData = modeQ;
      default:  cpuRdData = '0;
    endcase
  end

  assign addrEn  = addrQ[DATA_W-1];
  assign devAddr = addrQ[DEV_ADDR_W-1:0];
  assign epMode  = modeQ;

  // R3: bus reset empties the address register
  p_bus_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.addrClr |=> (addrQ == '0));

  // R2: a granted address write is visible next cycle
  p_addr_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.addrWr |=> (addrQ == $past(cpuWrData)));

  // R4: an accepted CPU write clears the status nibble and loads the mode nibble
  p_cpu_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (st.modeCpuWr && !st.setupForce) |=>
      (modeQ[DATA_W-1:MODE_W] == '0) && (modeQ[MODE_W-1:0] == $past(cpuWrData[MODE_W-1:0])));

  // R9: SETUP flag held during the window
  p_setup_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.setupForce |=> modeQ[SETUP_BIT]);

  // R5: the SIE field lands exactly as sent
  p_sie_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.modeSieWr |=> (modeQ[SIE_W-1:0] == $past(sieWrData)));

endmodule

// File: rtl/usb_ep0_regs.sv
module usb_ep0_regs
  import ep0_regs_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_OFS  = 8'h10,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  output logic [7:0]        cpuRdData,
  input  logic              sieWr,
  input  logic [6:0]        sieWrData,
  input  logic              setupWin,
  output logic              addrEn,
  output logic [6:0]        devAddr,
  output logic [7:0]        epMode
);

  ep0Strobes_t st;
  logic        lockQ;

  ep0_ctrl #(
    .ADDR_W  (ADDR_W),
    .DEV_OFS (DEV_OFS),
    .MODE_OFS(MODE_OFS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busRst  (busRst),
    .cpuAddr (cpuAddr),
    .cpuWr   (cpuWr),
    .cpuRd   (cpuRd),
    .sieWr   (sieWr),
    .setupWin(setupWin),
    .st      (st),
    .lockQ   (lockQ)
  );

  ep0_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .cpuWrData(cpuWrData),
    .sieWrData(sieWrData),
    .cpuRdData(cpuRdData),
    .addrEn   (addrEn),
    .devAddr  (devAddr),
    .epMode   (epMode)
  );

  // R5: while locked, a CPU write alone leaves the register as it was
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !sieWr && !setupWin) |=> $stable(epMode));

  // R10: a write to an unmapped address touches neither register
  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr != DEV_OFS && cpuAddr != MODE_OFS && !busRst && !sieWr && !setupWin)
      |=> ($stable(epMode) && $stable(devAddr) && $stable(addrEn)));

endmodule

// File: tb/usb_ep0_regs_tb.sv
module usb_ep0_regs_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busRst = 1'b0;
  logic [7:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic       cpuWr = 1'b0;
  logic       cpuRd = 1'b0;
  logic [7:0] cpuRdData;
  logic       sieWr = 1'b0;
  logic [6:0] sieWrData = '0;
  logic       setupWin = 1'b0;
  logic       addrEn;
  logic [6:0] devAddr;
  logic [7:0] epMode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mAddr = '0;
  logic [7:0] mMode = '0;
  logic       mLock = 1'b0;

  always #2.5 clk = ~clk;

  usb_ep0_regs u_dut (
    .clk(clk), .rstN(rstN), .busRst(busRst), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuRdData(cpuRdData),
    .sieWr(sieWr), .sieWrData(sieWrData), .setupWin(setupWin),
    .addrEn(addrEn), .devAddr(devAddr), .epMode(epMode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (a == 8'h10) return mAddr;
    if (a == 8'h12) return mMode;
    return 8'h00;
  endfunction

  // Requirement-level model of one clock edge
  task automatic modelEdge();
    logic [7:0] nMode;
    logic       nLock;
    nMode = mMode;
    nLock = mLock;
    if (busRst)                          mAddr = 8'h00;
    else if (cpuWr && cpuAddr == 8'h10)  mAddr = cpuWrData;
    if (sieWr) begin
      nMode[6:0] = sieWrData;
      nLock = 1'b1;
    end else begin
      if (cpuWr && cpuAddr == 8'h12 && !mLock) nMode = {4'h0, cpuWrData[3:0]};
      if (cpuRd && cpuAddr == 8'h12) nLock = 1'b0;
    end
    if (setupWin) nMode[7] = 1'b1;
    mMode = nMode;
    mLock = nLock;
  endtask

  task automatic cyc(input string req, input bit br, input logic [7:0] a, input logic [7:0] wd,
                     input bit wr, input bit rd, input bit sw, input logic [6:0] sd, input bit sup);
    busRst = br; cpuAddr = a; cpuWrData = wd; cpuWr = wr; cpuRd = rd;
    sieWr = sw; sieWrData = sd; setupWin = sup;
    #1;
    if (rd) chk({req, " read"}, 32'(cpuRdData), 32'(expRead(a)));
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk({req, " mode"}, 32'(epMode), 32'(mMode));
    chk({req, " addr"}, 32'({addrEn, devAddr}), 32'(mAddr));
  endtask

  task automatic idle();
    cyc("idle", 0, 8'h00, 8'h00, 0, 0, 0, 7'h00, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 epMode", 32'(epMode), 32'h0);
    chk("R1 addrEn", 32'(addrEn), 32'h0);
    chk("R1 devAddr", 32'(devAddr), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    cyc("R1", 0, 8'h10, 8'h00, 0, 1, 0, 7'h00, 0);
    cyc("R1", 0, 8'h12, 8'h00, 0, 1, 0, 7'h00, 0);

    // R2: address write
    cyc("R2", 0, 8'h10, 8'h85, 1, 0, 0, 7'h00, 0);
    chk("R2 addrEn", 32'(addrEn), 32'h1);
    chk("R2 devAddr", 32'(devAddr), 32'h05);
    cyc("R2", 0, 8'h10, 8'h00, 0, 1, 0, 7'h00, 0);

    // R3: bus reset beats a simultaneous write
    cyc("R3", 1, 8'h10, 8'hFF, 1, 0, 0, 7'h00, 0);
    chk("R3 devAddr", 32'({addrEn, devAddr}), 32'h0);

    // R4: unlocked write clears status nibble
    cyc("R4", 0, 8'h12, 8'hFF, 1, 0, 0, 7'h00, 0);
    chk("R4 value", 32'(epMode), 32'h0F);

    // R5: SIE update locks, CPU write dropped
    cyc("R5", 0, 8'h00, 8'h00, 0, 0, 1, 7'h55, 0);
    cyc("R5", 0, 8'h12, 8'h03, 1, 0, 0, 7'h00, 0);
    chk("R5 locked", 32'(epMode), 32'h55);

    // R6: read unlocks
    cyc("R6", 0, 8'h12, 8'h00, 0, 1, 0, 7'h00, 0);
    cyc("R6", 0, 8'h12, 8'h03, 1, 0, 0, 7'h00, 0);
    chk("R6 unlocked", 32'(epMode), 32'h03);

    // R7: SIE wins over same-cycle CPU write
    cyc("R7", 0, 8'h12, 8'h0A, 1, 0, 1, 7'h21, 0);
    chk("R7 sie wins", 32'(epMode), 32'h21);
    cyc("R7", 0, 8'h12, 8'h00, 1, 0, 0, 7'h00, 0);
    chk("R7 locked", 32'(epMode), 32'h21);

    // R8: read with SIE update keeps the lock
    cyc("R8", 0, 8'h12, 8'h00, 0, 1, 1, 7'h12, 0);
    cyc("R8", 0, 8'h12, 8'h00, 1, 0, 0, 7'h00, 0);
    chk("R8 still locked", 32'(epMode), 32'h12);
    cyc("R8", 0, 8'h12, 8'h00, 0, 1, 0, 7'h00, 0);
    cyc("R8", 0, 8'h12, 8'h00, 1, 0, 0, 7'h00, 0);
    chk("R8 released", 32'(epMode), 32'h00);

    // R9: SETUP window forces bit 7
    cyc("R9", 0, 8'h00, 8'h00, 0, 0, 0, 7'h00, 1);
    chk("R9 set", 32'(epMode), 32'h80);
    cyc("R9", 0, 8'h12, 8'h05, 1, 0, 0, 7'h00, 1);
    chk("R9 held", 32'(epMode), 32'h85);
    idle();
    chk("R9 kept", 32'(epMode), 32'h85);
    cyc("R9", 0, 8'h12, 8'h06, 1, 0, 0, 7'h00, 0);
    chk("R9 cleared", 32'(epMode), 32'h06);

    // R10: unmapped address
    cyc("R10", 0, 8'h11, 8'hFF, 1, 0, 0, 7'h00, 0);
    cyc("R10", 0, 8'h11, 8'h00, 0, 1, 0, 7'h00, 0);
    chk("R10 mode", 32'(epMode), 32'h06);

    // Constrained random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      int sel;
      sel = int'($urandom % 8);
      a = (sel < 3) ? 8'h10 : (sel < 7) ? 8'h12 : 8'($urandom);
      cyc("RND-R4", ($urandom % 20) == 0, a, 8'($urandom), ($urandom % 2) == 0,
          ($urandom % 3) == 0, ($urandom % 4) == 0, 7'($urandom), ($urandom % 6) == 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule